// File: doc/BRIEF.md
# Console Receiver Register Interface

This block is the processor-side register pair of a console serial receiver. A deserializer that is not part of this block hands over each received character as a one-cycle valid strobe with a byte. It can also send a separate one-cycle strobe when it detects a line break. The block keeps the character and its error flags in a 16-bit receive buffer. It sets a done flag and raises an interrupt request when interrupts are enabled. On a break it can also request a processor halt.

Software sees two registers. The status register holds the done flag and the interrupt-enable bit. The buffer register holds the character and its error flags. Reading the buffer has side effects: it consumes the character, clears the error flags and withdraws the interrupt. Bus decoding is reduced to one write strobe for the status register and one read strobe for the buffer. Both register values are always present on output ports.

Top module: `con_rx_regs`

## Requirements
- R1: After a synchronous reset, the buffer reads 0x0000, the status register reads 0x0000, and irq and halt_req are 0.
- R2: The status register shows done at bit 7 and interrupt-enable at bit 6. Every other bit always reads 0.
- R3: A status write stores only bit 6 of the write data. Bit 7 of the write data is ignored, so done does not change. The new value is visible the cycle after the write.
- R4: A status write with bit 6 clear drops a pending interrupt request on the next cycle.
- R5: A status write with bit 6 set, made while done is 1 and enable is 0, raises irq on the next cycle.
- R6: On a character strobe (rx_valid), the buffer low byte takes the character and done is set. irq rises if interrupt-enable is 1. The effect is visible the cycle after the strobe.
- R7: With mode8=0, the character is masked to its low 7 bits (bit 7 stored as 0). With mode8=1, all 8 bits are kept.
- R8: A character that arrives while done is still 1, and without a buffer read in the same cycle, is stored with overrun (bit 14) and error summary (bit 15) set: buffer = 0xC000 | character.
- R9: A buffer read strobe clears done, clears buffer bits 15:8 and drops irq on the next cycle. If a character or break arrives in the same cycle, the arrival wins and no overrun is flagged.
- R10: A break strobe loads the buffer with 0xA400: error summary bit 15, framing bit 13 and break bit 10. It sets done and raises irq if enabled. It takes priority over a simultaneous character. When halt_en is 1, halt_req is 1 for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a character has arrived |
| rx_char | input | 8 | Received character |
| rx_break | input | 1 | One-cycle strobe: a line break was detected |
| mode8 | input | 1 | 1 keeps 8-bit characters, 0 masks them to 7 bits |
| halt_en | input | 1 | Allows a break to request a halt |
| stat_wr | input | 1 | Write strobe for the status register |
| stat_wdata | input | 16 | Status write data (only bit 6 is used) |
| buf_rd | input | 1 | Read strobe for the buffer register (side-effecting) |
| stat_q | output | 16 | Status register value |
| buf_q | output | 16 | Receive buffer value |
| irq | output | 1 | Receive interrupt request |
| halt_req | output | 1 | Halt request, one cycle after an enabled break |

## Verification
The bench builds the block at its default sizes: a 16-bit buffer and an 8-bit character path. At these sizes the 7-bit mask, all four error bit positions and the high-byte clearing on read are reachable. Directed sequences then cover the priority cases: a character arriving on top of an unread one, a read colliding with a new arrival, a break colliding with a character, and enable being toggled while done is set.

// File: rtl/con_rx_pkg.sv
package con_rx_pkg;
  localparam int BUF_W    = 16;
  localparam int CHR_W    = 8;
  localparam int B_ERRSUM = 15;
  localparam int B_OVRUN  = 14;
  localparam int B_FRAME  = 13;
  localparam int B_BREAK  = 10;
  localparam int S_DONE   = 7;
  localparam int S_IE     = 6;
endpackage

// File: rtl/con_rx_status.sv
module con_rx_status (
  input  logic clk,
  input  logic rst,
  input  logic arrive,
  input  logic rd_clr,
  input  logic wr,
  input  logic wr_ie,
  output logic done_q,
  output logic ie_q,
  output logic irq_q
);
  logic ie_d, irq_d, done_d;

  always_comb begin
    ie_d   = wr ? wr_ie : ie_q;
    done_d = arrive ? 1'b1 : (rd_clr ? 1'b0 : done_q);
    irq_d  = irq_q;
    if (wr && !wr_ie)
      irq_d = 1'b0;
    else if (wr && wr_ie && done_q && !ie_q)
      irq_d = 1'b1;
    if (rd_clr)
      irq_d = 1'b0;
    if (arrive && ie_d)
      irq_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      ie_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      ie_q   <= ie_d;
      irq_q  <= irq_d;
    end
  end
endmodule

// File: rtl/con_rx_buffer.sv
module con_rx_buffer
  import con_rx_pkg::*;
#(
  parameter int DATA_W = BUF_W,
  parameter int CHAR_W = CHR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_char,
  input  logic              load_brk,
  input  logic              overrun,
  input  logic              mode8,
  input  logic [CHAR_W-1:0] char_in,
  input  logic              rd_clr,
  output logic [DATA_W-1:0] buf_q
);
  localparam int NARROW_W = CHAR_W - 1;
  localparam logic [CHAR_W-1:0] NARROW_MASK = {1'b0, {NARROW_W{1'b1}}};

  logic [CHAR_W-1:0] char_m;
  logic [DATA_W-1:0] char_word, brk_word, flags_word;

  always_comb begin
    char_m     = mode8 ? char_in : (char_in & NARROW_MASK);
    char_word  = '0;
    char_word[CHAR_W-1:0] = char_m;
    flags_word = '0;
    flags_word[B_ERRSUM] = overrun;
    flags_word[B_OVRUN]  = overrun;
    brk_word   = '0;
    brk_word[B_ERRSUM] = 1'b1;
    brk_word[B_FRAME]  = 1'b1;
    brk_word[B_BREAK]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      buf_q <= '0;
    else if (load_brk)
      buf_q <= brk_word;
    else if (load_char)
      buf_q <= char_word | flags_word;
    else if (rd_clr)
      buf_q[DATA_W-1:CHAR_W] <= '0;
  end
endmodule

// File: rtl/con_rx_regs.sv
module con_rx_regs
  import con_rx_pkg::*;
#(
  parameter int DATA_W = BUF_W,
  parameter int CHAR_W = CHR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              rx_break,
  input  logic              mode8,
  input  logic              halt_en,
  input  logic              stat_wr,
  input  logic [DATA_W-1:0] stat_wdata,
  input  logic              buf_rd,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] buf_q,
  output logic              irq,
  output logic              halt_req
);
  logic done_q, ie_q, arrive;

  assign arrive = rx_valid | rx_break;

  con_rx_status u_status (
    .clk    (clk),
    .rst    (rst),
    .arrive (arrive),
    .rd_clr (buf_rd),
    .wr     (stat_wr),
    .wr_ie  (stat_wdata[S_IE]),
    .done_q (done_q),
    .ie_q   (ie_q),
    .irq_q  (irq)
  );

  con_rx_buffer #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_buffer (
    .clk       (clk),
    .rst       (rst),
    .load_char (rx_valid),
    .load_brk  (rx_break),
    .overrun   (done_q & ~buf_rd),
    .mode8     (mode8),
    .char_in   (rx_char),
    .rd_clr    (buf_rd),
    .buf_q     (buf_q)
  );

  always_comb begin
    stat_q         = '0;
    stat_q[S_DONE] = done_q;
    stat_q[S_IE]   = ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) halt_req <= 1'b0;
    else     halt_req <= rx_break & halt_en;
  end
endmodule

// File: rtl/con_rx_regs_chk.sv
module con_rx_regs_chk #(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic [CHAR_W-1:0] rx_char,
  input logic              rx_break,
  input logic              mode8,
  input logic              halt_en,
  input logic              stat_wr,
  input logic [DATA_W-1:0] stat_wdata,
  input logic              buf_rd,
  input logic [DATA_W-1:0] stat_q,
  input logic [DATA_W-1:0] buf_q,
  input logic              irq,
  input logic              halt_req
);
  p_stat_reserved_r2: assert property (@(posedge clk) disable iff (rst)
    (stat_q & ~16'h00C0) == 16'h0000);

  p_irq_needs_done_ie_r6: assert property (@(posedge clk) disable iff (rst)
    irq |-> (stat_q[7] && stat_q[6]));

  p_ie_write_r3: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !rx_valid && !rx_break && !buf_rd) |=>
      (stat_q[6] == $past(stat_wdata[6])) && (stat_q[7] == $past(stat_q[7])));

  p_overrun_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_break && !buf_rd && stat_q[7]) |=> (buf_q[15:14] == 2'b11));

  p_read_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (buf_rd && !rx_valid && !rx_break) |=>
      (!irq && !stat_q[7] && buf_q[15:8] == 8'h00));

  p_break_pattern_r10: assert property (@(posedge clk) disable iff (rst)
    rx_break |=> (buf_q == 16'hA400 && stat_q[7]));

  p_halt_on_r10: assert property (@(posedge clk) disable iff (rst)
    (rx_break && halt_en) |=> halt_req);

  p_halt_off_r10: assert property (@(posedge clk) disable iff (rst)
    !(rx_break && halt_en) |=> !halt_req);
endmodule

bind con_rx_regs con_rx_regs_chk #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_chk (.*);

// File: tb/con_rx_regs_tb.sv
module con_rx_regs_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0, rx_break = 1'b0, mode8 = 1'b1, halt_en = 1'b0;
  logic stat_wr = 1'b0, buf_rd = 1'b0;
  logic [7:0]  rx_char = 8'h00;
  logic [15:0] stat_wdata = 16'h0000;
  logic [15:0] stat_q, buf_q;
  logic irq, halt_req;

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";
  bit finished = 1'b0;

  int m_buf = 0, m_done = 0, m_ie = 0, m_irq = 0, m_halt = 0;

  always #5 clk = ~clk;

  con_rx_regs u_dut (.*);

  // behavioural reference, updated from the inputs present at each edge
  always @(posedge clk) begin
    int arr, nie, nirq, c;
    if (rst) begin
      m_buf = 0; m_done = 0; m_ie = 0; m_irq = 0; m_halt = 0;
    end else begin
      arr  = (rx_valid || rx_break) ? 1 : 0;
      nie  = stat_wr ? int'(stat_wdata[6]) : m_ie;
      nirq = m_irq;
      if (stat_wr && !stat_wdata[6]) nirq = 0;
      else if (stat_wr && stat_wdata[6] && m_done == 1 && m_ie == 0) nirq = 1;
      if (buf_rd) nirq = 0;
      if (arr == 1 && nie == 1) nirq = 1;
      if (rx_break) m_buf = 'hA400;
      else if (rx_valid) begin
        c = mode8 ? int'(rx_char) : int'(rx_char) & 'h7F;
        m_buf = c | ((m_done == 1 && !buf_rd) ? 'hC000 : 0);
      end else if (buf_rd) m_buf = m_buf & 'hFF;
      if (arr == 1) m_done = 1;
      else if (buf_rd) m_done = 0;
      m_ie = nie;
      m_irq = nirq;
      m_halt = (rx_break && halt_en) ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    int exp_stat;
    if (!finished) begin
      exp_stat = (m_done << 7) | (m_ie << 6);
      n_cmp++;
      if (int'(buf_q) != m_buf || int'(stat_q) != exp_stat ||
          int'(irq) != m_irq || int'(halt_req) != m_halt) begin
        n_bad++;
        $display("FAIL %s: buf=%h stat=%h irq=%0d halt=%0d expected buf=%h stat=%h irq=%0d halt=%0d",
                 tag, buf_q, stat_q, irq, halt_req, m_buf[15:0], exp_stat[15:0], m_irq, m_halt);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 0; rx_break = 0; stat_wr = 0; buf_rd = 0;
    end
  endtask

  task automatic put_char(input logic [7:0] c);
    @(negedge clk); rx_valid = 1; rx_char = c;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic wr_stat(input logic [15:0] d);
    @(negedge clk); stat_wr = 1; stat_wdata = d;
    @(negedge clk); stat_wr = 0;
  endtask

  task automatic rd_buf();
    @(negedge clk); buf_rd = 1;
    @(negedge clk); buf_rd = 0;
  endtask

  task automatic send_break();
    @(negedge clk); rx_break = 1;
    @(negedge clk); rx_break = 0;
  endtask

  initial begin
    tag = "R1"; rst = 1; idle(3);
    @(negedge clk); rst = 0; idle(2);
    tag = "R3"; wr_stat(16'hFFBF); wr_stat(16'h0080); idle(1);
    tag = "R2"; wr_stat(16'hFFFF); idle(1);
    tag = "R6"; put_char(8'hC5); idle(2);
    tag = "R9"; rd_buf(); idle(1);
    tag = "R7"; mode8 = 0; put_char(8'hE1); rd_buf(); mode8 = 1; put_char(8'hE1); rd_buf();
    tag = "R8"; put_char(8'h41); put_char(8'h42); idle(1); rd_buf(); idle(1);
    tag = "R4"; put_char(8'h10); wr_stat(16'h0000); idle(2);
    tag = "R5"; wr_stat(16'h0040); idle(2); rd_buf();
    tag = "R9"; put_char(8'h20);
    @(negedge clk); buf_rd = 1; rx_valid = 1; rx_char = 8'h33;
    @(negedge clk); buf_rd = 0; rx_valid = 0; idle(1); rd_buf();
    tag = "R10"; halt_en = 1; send_break(); idle(2); rd_buf();
    halt_en = 0; send_break(); idle(1);
    halt_en = 1;
    @(negedge clk); rx_break = 1; rx_valid = 1; rx_char = 8'h55;
    @(negedge clk); rx_break = 0; rx_valid = 0; idle(2); rd_buf();
    tag = "R4"; wr_stat(16'h0000); send_break(); idle(2);
    tag = "R1"; @(negedge clk); rst = 1; idle(1); @(negedge clk); rst = 0; idle(2);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule